// File: doc/BRIEF.md
# Dual-Addressed Push-Down List Buffer

This block is a word-wide scratch memory of 1024 entries that serves as a hardware stack. Two separate address registers can reach the storage. The first is a stack pointer that moves on push and pop. The second is an index register that gives random access without disturbing the stack.

A single write port takes a destination code and a data word in each cycle. The destination code selects one of these actions:
- store at the pointer;
- push;
- store at the index;
- load the index register;
- load the pointer register.

The read port always presents the entry at the current pointer as a combinational value, so a consumer can sample the top of stack in the same cycle it asks for it. Asserting the pop strobe with that read moves the pointer down at the next clock edge. Both address registers are visible on output ports, so software-style sequences can read them back.

Reset is asynchronous and active low. Its release is synchronised to the clock inside the block. Reset clears both address registers. The storage contents are not initialised.

Top module: `pdl_buffer`

## Requirements
- R1: While reset is active and after it is released, with no other activity, `ptr_q` and `idx_q` read 0.
- R2: Destination code 4 loads `ptr_q` and destination code 3 loads `idx_q`. In both cases the register takes bits [9:0] of `wr_data` and ignores the upper bits. The new value is visible after the next clock edge.
- R3: Destination code 1 (push) first increments the pointer modulo 1024 and then stores `wr_data` at the incremented location. A push from 1023 lands at 0.
- R4: With `rd_pop`=1, `rd_data` in that cycle shows the entry at the current pointer. After the edge, the pointer is one lower modulo 1024, so a pop from 0 leaves 1023.
- R5: With `rd_pop`=0 and no pointer-changing write, `rd_data` shows the entry at the pointer and the pointer does not change.
- R6: Destination code 0 stores `wr_data` at the current pointer location. The pointer does not change.
- R7: Destination code 2 stores `wr_data` at the location held in `idx_q`. Neither `ptr_q` nor `idx_q` changes.
- R8: If a pointer load (code 4) and a pop happen in the same cycle, `rd_data` still shows the old top, and the pointer takes the loaded value.
- R9: If a push and a pop happen in the same cycle, `rd_data` shows the old top, the pointer keeps its value, and the pushed word replaces the entry at that pointer.
- R10: The following leave the pointer, the index and all storage unchanged:
  - destination codes 5, 6 and 7;
  - any code presented with `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write port strobe |
| wr_dst | input | 3 | Destination code (0 at-pointer, 1 push, 2 at-index, 3 load index, 4 load pointer) |
| wr_data | input | DATA_W | Write data word |
| rd_pop | input | 1 | Pop the stack top this cycle |
| rd_data | output | DATA_W | Entry at the current pointer (combinational) |
| ptr_q | output | PTR_W | Stack pointer |
| idx_q | output | PTR_W | Index register |

## Verification
The embedded properties check on every cycle how each address register may move:
- the pointer steps by exactly one on a lone push or a lone pop;
- the pointer stays put when neither happens;
- a pointer load overrides any concurrent step;
- the index changes only on its own load;
- the decoder never raises more than one write action, and raises none for spare codes.

Some behaviour only the bench sweeps can show:
- storage contents, including LIFO order across the full 1024-entry wrap in both directions;
- the exact location a push lands on;
- writes by index that leave the stack intact;
- the combined push-and-pop replacement.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic [2:0] {
    DST_AT_PTR = 3'd0,
    DST_PUSH   = 3'd1,
    DST_AT_IDX = 3'd2,
    DST_LD_IDX = 3'd3,
    DST_LD_PTR = 3'd4
  } pdl_dst_e;

  typedef struct packed {
    logic wr_ptr;
    logic push;
    logic wr_idx;
    logic ld_idx;
    logic ld_ptr;
    logic pop;
  } pdl_ctl_t;

endpackage

// File: rtl/pdl_rst_sync.sv
module pdl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pdl_decode.sv
module pdl_decode
  import pdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       wr_en,
  input  logic [2:0] wr_dst,
  input  logic       rd_pop,
  output pdl_ctl_t   ctl
);

  always_comb begin
    ctl     = '0;
    ctl.pop = rd_pop;
    if (wr_en) begin
      case (wr_dst)
        DST_AT_PTR: ctl.wr_ptr = 1'b1;
        DST_PUSH:   ctl.push   = 1'b1;
        DST_AT_IDX: ctl.wr_idx = 1'b1;
        DST_LD_IDX: ctl.ld_idx = 1'b1;
        DST_LD_PTR: ctl.ld_ptr = 1'b1;
        default:    ;
      endcase
    end
  end

  // R10: at most one write action per cycle
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ctl.wr_ptr, ctl.push, ctl.wr_idx, ctl.ld_idx, ctl.ld_ptr}));

  // R10: spare codes or an idle port raise no write action
  a_r10_spare_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_en || wr_dst > 3'd4) |->
      ({ctl.wr_ptr, ctl.push, ctl.wr_idx, ctl.ld_idx, ctl.ld_ptr} == 5'b0));

endmodule

// File: rtl/pdl_addr_unit.sv
module pdl_addr_unit
  import pdl_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  pdl_ctl_t         ctl,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] idx_q,
  output logic [PTR_W-1:0] waddr,
  output logic             we
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_d, idx_d, ptr_inc, ptr_dec;
  logic             ptr_en, idx_en;

  always_comb begin
    ptr_inc = ptr_q + ONE;
    ptr_dec = ptr_q - ONE;
    ptr_en  = ctl.ld_ptr | ctl.push | ctl.pop;
    ptr_d   = ptr_q;
    if (ctl.ld_ptr)                ptr_d = ld_val;
    else if (ctl.push && !ctl.pop) ptr_d = ptr_inc;
    else if (ctl.pop && !ctl.push) ptr_d = ptr_dec;
    idx_en = ctl.ld_idx;
    idx_d  = ld_val;
  end

  always_comb begin
    we = ctl.wr_ptr | ctl.push | ctl.wr_idx;
    if (ctl.wr_idx)    waddr = idx_q;
    else if (ctl.push) waddr = ctl.pop ? ptr_q : ptr_inc;
    else               waddr = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // R2 / R8: a pointer load wins over any step
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl.ld_ptr |=> ptr_q == $past(ld_val));

  a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl.push && !ctl.pop && !ctl.ld_ptr) |=> ptr_q == $past(ptr_q) + ONE);

  a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl.pop && !ctl.push && !ctl.ld_ptr) |=> ptr_q == $past(ptr_q) - ONE);

  // R5 / R6 / R9: pointer holds when no net movement
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctl.ld_ptr && (ctl.push == ctl.pop)) |=> $stable(ptr_q));

  // R7: index changes only on its own load
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl.ld_idx |=> $stable(idx_q));

  a_r2_idx_load: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl.ld_idx |=> idx_q == $past(ld_val));

endmodule

// File: rtl/pdl_store.sv
module pdl_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pdl_buffer.sv
module pdl_buffer
  import pdl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 1024,
  parameter int RST_STAGE = 2,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_dst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [PTR_W-1:0]  idx_q
);

  logic             rst_ni;
  pdl_ctl_t         ctl;
  logic [PTR_W-1:0] waddr;
  logic             we;

  pdl_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  pdl_decode u_dec (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_dst(wr_dst),
    .rd_pop(rd_pop), .ctl(ctl)
  );

  pdl_addr_unit #(.PTR_W(PTR_W)) u_addr (
    .clk(clk), .rst_ni(rst_ni), .ctl(ctl), .ld_val(wr_data[PTR_W-1:0]),
    .ptr_q(ptr_q), .idx_q(idx_q), .waddr(waddr), .we(we)
  );

  pdl_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(ptr_q), .rdata(rd_data)
  );

  // R1: address registers are zero while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_ni |=> (ptr_q == '0 && idx_q == '0));

endmodule

// File: tb/test_pdl_buffer.sv
module test_pdl_buffer;

  localparam int N = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_dst;
  logic [31:0] wr_data;
  logic        rd_pop;
  logic [31:0] rd_data;
  logic [9:0]  ptr_q, idx_q;

  pdl_buffer i_pdl_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dst(wr_dst),
    .wr_data(wr_data), .rd_pop(rd_pop), .rd_data(rd_data),
    .ptr_q(ptr_q), .idx_q(idx_q)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] m_mem [N];
  bit          m_ok  [N];
  logic [9:0]  m_ptr = '0;
  logic [9:0]  m_idx = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle after a falling edge, update the model, check after the next fall.
  task automatic op(bit en, logic [2:0] dst, logic [31:0] d, bit pop, string tag);
    logic [9:0] wa;
    bit         wr;
    wr_en = en; wr_dst = dst; wr_data = d; rd_pop = pop;
    #1;
    if (m_ok[m_ptr]) chk(tag, rd_data, m_mem[m_ptr]);
    wr = en && (dst <= 3'd2);
    wa = (dst == 3'd2) ? m_idx : (dst == 3'd1) ? (pop ? m_ptr : m_ptr + 10'd1) : m_ptr;
    if (wr) begin m_mem[wa] = d; m_ok[wa] = 1'b1; end
    if (en && dst == 3'd4)      m_ptr = d[9:0];
    else if (en && dst == 3'd1) m_ptr = pop ? m_ptr : m_ptr + 10'd1;
    else if (pop)               m_ptr = m_ptr - 10'd1;
    if (en && dst == 3'd3) m_idx = d[9:0];
    @(posedge clk); @(negedge clk);
    chk(tag, 32'(ptr_q), 32'(m_ptr));
    chk(tag, 32'(idx_q), 32'(m_idx));
  endtask

  function automatic logic [31:0] pat(int i, int salt);
    return (32'(i) * 32'h9E37_79B1) ^ 32'(salt);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) m_ok[i] = 1'b0;
    rst_n = 1'b0; wr_en = 0; wr_dst = 0; wr_data = 0; rd_pop = 0;
    repeat (3) @(negedge clk);
    chk("R1", 32'(ptr_q), 0); chk("R1", 32'(idx_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 32'(ptr_q), 0); chk("R1", 32'(idx_q), 0);

    // R2: loads keep only the low ten bits
    op(1, 3'd4, 32'hFFFF_F3FF, 0, "R2");
    op(1, 3'd3, 32'hABCD_E805, 0, "R2");
    chk("R2", 32'(ptr_q), 32'h3FF);
    chk("R2", 32'(idx_q), 32'h005);

    // R3: pushes from 1023 wrap through 0 and fill every slot
    for (int i = 0; i < N; i++) op(1, 3'd1, pat(i, 1), 0, "R3");
    chk("R3", 32'(ptr_q), 32'h3FF);

    // R5: peek leaves the pointer alone
    op(0, 3'd0, 0, 0, "R5");
    chk("R5", rd_data, pat(N-1, 1));

    // R4: pops return LIFO order and wrap from 0 to 1023
    for (int i = 0; i < N; i++) op(0, 3'd0, 0, 1, "R4");
    chk("R4", 32'(ptr_q), 32'h3FF);

    // R7: writes by index leave the pointer alone; read back by pointer loads
    for (int i = 0; i < N; i++) begin
      op(1, 3'd3, 32'(i), 0, "R7");
      op(1, 3'd2, pat(i, 7), 0, "R7");
    end
    for (int i = 0; i < N; i += 37) begin
      op(1, 3'd4, 32'(i), 0, "R7");
      op(0, 3'd0, 0, 0, "R7");
      chk("R7", rd_data, pat(i, 7));
    end

    // R6: write at pointer
    op(1, 3'd4, 32'd37, 0, "R6");
    op(1, 3'd0, 32'hCAFE_0037, 0, "R6");
    op(0, 3'd0, 0, 0, "R6");
    chk("R6", rd_data, 32'hCAFE_0037);
    chk("R6", 32'(ptr_q), 37);

    // R8: pointer load beats a concurrent pop
    op(1, 3'd4, 32'd500, 1, "R8");
    chk("R8", 32'(ptr_q), 500);

    // R9: push with pop replaces the top in place
    op(1, 3'd1, 32'h1234_5678, 1, "R9");
    chk("R9", 32'(ptr_q), 500);
    op(0, 3'd0, 0, 0, "R9");
    chk("R9", rd_data, 32'h1234_5678);

    // R10: spare codes and idle port change nothing
    for (int c = 5; c < 8; c++) op(1, 3'(c), 32'hDEAD_BEEF, 0, "R10");
    op(0, 3'd1, 32'hDEAD_BEEF, 0, "R10");
    op(0, 3'd2, 32'hDEAD_BEEF, 0, "R10");
    chk("R10", rd_data, 32'h1234_5678);
    op(1, 3'd4, 32'd501, 0, "R10");
    chk("R10", rd_data, pat(501, 7));
    op(1, 3'd4, 32'(m_idx), 0, "R10");
    chk("R10", rd_data, m_mem[m_idx]);

    finish_run();
  end

endmodule